// File: doc/BRIEF.md
# Dual-Clock Prefetching FIFO with Level Flags

This block buffers 18-bit words between two free-running clocks that may be unrelated or may be one and the same. A writer stores words in the write-clock domain and a reader removes them in the read-clock domain. Pointers cross between the domains as Gray codes through two-stage synchronisers. Full and empty are therefore seen late but never early.

The block prefetches. Once the memory holds a word and the output register is empty, the oldest word moves into the output register and the output-ready flag rises. No read request is needed for this, so the reader sees valid data before it asks for it. A read then discards the presented word and fetches the next one. The memory holds 256 words and the output register holds one more, so 257 words fit in total.

The write domain also drives a half-full flag and an edge-warning flag. The edge-warning flag rises when the memory is nearly empty or nearly full, by an offset that software can set. A single active-high reset clears both domains. Each domain brings the reset in through its own synchroniser, so the reset must be held for at least four edges of each clock.

Top module: `dcfifo_prefetch`

## Requirements
- R1: While the reset is held for at least four edges of each clock, `in_rdy`, `out_rdy` and `half_full` are low and `edge_warn` is high. Within a few write-clock cycles after the reset is released, `in_rdy` goes high.
- R2: A word on `d` is stored at a rising `wclk` edge only when `wr_en_hi`=1, `wr_en_lo_n`=0, `prg_n`=1 and `in_rdy`=1. Any other combination stores nothing.
- R3: The presented word is consumed at a rising `rclk` edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_rdy` is 1. Otherwise the output register and `out_rdy` keep their values.
- R4: When the memory holds a word and `out_rdy` is low, that word moves into the output register and `out_rdy` rises. This happens with no read request and whatever the levels of `rd_en_n`, `oe_a_n` and `oe_b_n`.
- R5: Words leave in the order they were written and with their values unchanged, also when writes and reads come at unrelated rates on unrelated clocks.
- R6: `in_rdy` falls when the memory holds 256 words, which is 257 words written with none read. It rises again after reads free space.
- R7: `half_full` is 1 exactly when the memory holds at least 129 words, as seen from the write domain.
- R8: `edge_warn` is 1 when the memory count is at most the offset or at least 256 minus the offset. After reset the offset is 32.
- R9: At a `wclk` edge with `prg_n`=0, the offset is loaded from `d[7:0]`. No word is stored at that edge.
- R10: `q` carries the output register only when `oe_a_n` and `oe_b_n` are both 0. Otherwise `q` is high-impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Active-high reset, brought into each domain through a synchroniser |
| d | input | 18 | Write data; bits 7:0 also carry the offset value |
| wr_en_hi | input | 1 | Write enable, active high |
| wr_en_lo_n | input | 1 | Write enable, active low |
| prg_n | input | 1 | Offset load strobe, active low |
| in_rdy | output | 1 | Space available (write domain) |
| half_full | output | 1 | Memory count at least 129 (write domain) |
| edge_warn | output | 1 | Memory count near empty or near full (write domain) |
| rd_en_n | input | 1 | Read request, active low |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| q | output | 18 | Read data, high-impedance unless both output enables are low |
| out_rdy | output | 1 | Valid word in the output register (read domain) |

## Verification
Damage to the write pointer or to its Gray encoding shows up on `q` as a skipped, repeated or stale word. It appears once the reader reaches that slot, at most 257 reads later. Damage to the synchronised pointer counts shows up in the flags at the next write-clock edge: `half_full`, `edge_warn` or `in_rdy` then sits on the wrong side of a threshold that the bench steps across one word at a time. If the prefetch or the read gating is wrong, `out_rdy` and `q` are wrong within two or three read-clock cycles of the triggering write or read request.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    localparam int unsigned DATA_W     = 18;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned PTR_W      = ADDR_W + 1;
    localparam int unsigned DEPTH      = 1 << ADDR_W;
    localparam int unsigned HALF_MARK  = DEPTH / 2 + 1;
    localparam int unsigned DEF_OFFSET = 32;

    typedef logic [PTR_W-1:0]  ptr_w_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        ptr_w_t bin;
        ptr_w_t gray;
    } ptr_t;

    function automatic ptr_w_t bin2gray(input ptr_w_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_w_t gray2bin(input ptr_w_t g);
        ptr_w_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic ptr_t ptr_step(input ptr_t p, input logic inc);
        ptr_t n;
        n.bin  = p.bin + {{(PTR_W-1){1'b0}}, inc};
        n.gray = bin2gray(n.bin);
        return n;
    endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
    import dcfifo_pkg::*;
(
    input  logic   clk,
    input  logic   rst_s,
    input  logic   en_hi,
    input  logic   en_lo_n,
    input  logic   prg_n,
    input  addr_t  prg_val,
    input  ptr_w_t rgray_s,
    output logic   we,
    output addr_t  waddr,
    output ptr_w_t wgray,
    output logic   in_rdy,
    output logic   half_full,
    output logic   edge_warn
);
    ptr_t   wp, wp_nx;
    addr_t  offset;
    ptr_w_t rbin_s;
    ptr_w_t occ;

    assign we     = en_hi & ~en_lo_n & prg_n & in_rdy;
    assign wp_nx  = ptr_step(wp, we);
    assign rbin_s = gray2bin(rgray_s);
    assign occ    = wp_nx.bin - rbin_s;
    assign waddr  = wp.bin[ADDR_W-1:0];
    assign wgray  = wp.gray;

    always_ff @(posedge clk) begin
        if (rst_s) begin
            wp        <= '0;
            in_rdy    <= 1'b0;
            half_full <= 1'b0;
            edge_warn <= 1'b1;
            offset    <= addr_t'(DEF_OFFSET);
        end else begin
            wp        <= wp_nx;
            in_rdy    <= (occ != ptr_w_t'(DEPTH));
            half_full <= (occ >= ptr_w_t'(HALF_MARK));
            edge_warn <= (occ <= {1'b0, offset}) ||
                         (occ >= ptr_w_t'(DEPTH) - {1'b0, offset});
            if (!prg_n) offset <= prg_val;
        end
    end
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
    import dcfifo_pkg::*;
(
    input  logic   clk,
    input  logic   rst_s,
    input  logic   rd_en_n,
    input  logic   oe_a_n,
    input  logic   oe_b_n,
    input  ptr_w_t wgray_s,
    input  word_t  rdata,
    output addr_t  raddr,
    output ptr_w_t rgray,
    output word_t  qreg,
    output logic   out_rdy
);
    ptr_t rp;
    logic empty, take, load;

    assign empty = (rp.gray == wgray_s);
    assign take  = out_rdy & ~rd_en_n & ~oe_a_n & ~oe_b_n;
    assign load  = ~empty & (~out_rdy | take);
    assign raddr = rp.bin[ADDR_W-1:0];
    assign rgray = rp.gray;

    always_ff @(posedge clk) begin
        if (rst_s) begin
            rp      <= '0;
            qreg    <= '0;
            out_rdy <= 1'b0;
        end else if (load) begin
            rp      <= ptr_step(rp, 1'b1);
            qreg    <= rdata;
            out_rdy <= 1'b1;
        end else if (take) begin
            out_rdy <= 1'b0;
        end
    end
endmodule

// File: rtl/dcfifo_prefetch.sv
module dcfifo_prefetch
    import dcfifo_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d,
    input  logic              wr_en_hi,
    input  logic              wr_en_lo_n,
    input  logic              prg_n,
    output logic              in_rdy,
    output logic              half_full,
    output logic              edge_warn,
    input  logic              rd_en_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    output logic [DATA_W-1:0] q,
    output logic              out_rdy
);
    logic   wrst, rrst, we;
    addr_t  waddr, raddr;
    ptr_w_t wgray, rgray, wgray_s, rgray_s;
    word_t  qreg;
    word_t  mem [DEPTH];

    dcfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst (
        .clk(wclk), .clr(1'b0), .din(rst), .dout(wrst));
    dcfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rrst (
        .clk(rclk), .clr(1'b0), .din(rst), .dout(rrst));

    dcfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .clr(wrst), .din(rgray), .dout(rgray_s));
    dcfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .clr(rrst), .din(wgray), .dout(wgray_s));

    dcfifo_wr_side u_wr (
        .clk(wclk), .rst_s(wrst), .en_hi(wr_en_hi), .en_lo_n(wr_en_lo_n),
        .prg_n(prg_n), .prg_val(d[ADDR_W-1:0]), .rgray_s(rgray_s),
        .we(we), .waddr(waddr), .wgray(wgray), .in_rdy(in_rdy),
        .half_full(half_full), .edge_warn(edge_warn));

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= d;
    end

    dcfifo_rd_side u_rd (
        .clk(rclk), .rst_s(rrst), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n),
        .oe_b_n(oe_b_n), .wgray_s(wgray_s), .rdata(mem[raddr]),
        .raddr(raddr), .rgray(rgray), .qreg(qreg), .out_rdy(out_rdy));

    assign q = (!oe_a_n && !oe_b_n) ? qreg : {DATA_W{1'bz}};
endmodule

// File: rtl/dcfifo_checker.sv
module dcfifo_checker
    import dcfifo_pkg::*;
(
    input logic   wclk,
    input logic   rclk,
    input logic   rst,
    input logic   wrst,
    input logic   rrst,
    input logic   in_rdy,
    input logic   half_full,
    input logic   edge_warn,
    input logic   out_rdy,
    input logic   rd_en_n,
    input logic   oe_a_n,
    input logic   oe_b_n,
    input ptr_w_t wgray,
    input ptr_w_t rgray,
    input word_t  qreg
);
    assert_wr_reset_flags_R1: assert property (@(posedge wclk) disable iff (rst)
        $fell(wrst) |-> (!in_rdy && !half_full && edge_warn));

    assert_rd_reset_flag_R1: assert property (@(posedge rclk) disable iff (rst)
        $fell(rrst) |-> !out_rdy);

    assert_no_write_when_blocked_R2: assert property (@(posedge wclk) disable iff (rst || wrst)
        !in_rdy |=> $stable(wgray));

    assert_hold_without_read_R3: assert property (@(posedge rclk) disable iff (rst || rrst)
        (out_rdy && !(!rd_en_n && !oe_a_n && !oe_b_n)) |=> (out_rdy && $stable(qreg)));

    assert_wgray_single_step_R5: assert property (@(posedge wclk) disable iff (rst || wrst)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_single_step_R5: assert property (@(posedge rclk) disable iff (rst || rrst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind dcfifo_prefetch dcfifo_checker u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wrst(wrst), .rrst(rrst),
    .in_rdy(in_rdy), .half_full(half_full), .edge_warn(edge_warn),
    .out_rdy(out_rdy), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .wgray(wgray), .rgray(rgray), .qreg(qreg));

// File: tb/tb_dcfifo_prefetch.sv
module tb_dcfifo_prefetch;
    localparam int CLK_PERIOD = 10;
    localparam int R_PERIOD   = 14;
    localparam int W          = 18;

    logic wclk = 0, rclk = 0, rst = 1;
    logic [W-1:0] d = '0;
    logic wr_en_hi = 0, wr_en_lo_n = 1, prg_n = 1;
    logic rd_en_n = 1, oe_a_n = 1, oe_b_n = 1;
    logic in_rdy, half_full, edge_warn, out_rdy;
    wire  [W-1:0] q;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [W-1:0] model [$];

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(R_PERIOD/2)   rclk = ~rclk;

    dcfifo_prefetch dut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .d(d), .wr_en_hi(wr_en_hi),
        .wr_en_lo_n(wr_en_lo_n), .prg_n(prg_n), .in_rdy(in_rdy),
        .half_full(half_full), .edge_warn(edge_warn), .rd_en_n(rd_en_n),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .q(q), .out_rdy(out_rdy));

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_w(input int n);
        repeat (n) @(negedge wclk);
    endtask

    task automatic wait_r(input int n);
        repeat (n) @(negedge rclk);
    endtask

    task automatic push(input logic [W-1:0] val);
        @(negedge wclk);
        while (!in_rdy) @(negedge wclk);
        d = val; wr_en_hi = 1; wr_en_lo_n = 0;
        model.push_back(val);
        @(negedge wclk);
        wr_en_hi = 0; wr_en_lo_n = 1;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        oe_a_n = 0; oe_b_n = 0;
        while (model.size() > 0 && guard < 4000) begin
            @(negedge rclk);
            guard++;
            if (out_rdy) begin
                check(req, q, model.pop_front());
                rd_en_n = 0;
            end else begin
                rd_en_n = 1;
            end
        end
        @(negedge rclk);
        rd_en_n = 1;
        check({req, " all words out"}, W'(model.size()), '0);
        wait_r(8);
        check({req, " no extra word"}, W'(out_rdy), '0);
        oe_a_n = 1; oe_b_n = 1;
    endtask

    task automatic t_reset;
        rst = 1;
        wait_w(6); wait_r(6);
        check("R1 in_rdy in reset", W'(in_rdy), '0);
        check("R1 out_rdy in reset", W'(out_rdy), '0);
        check("R1 half_full in reset", W'(half_full), '0);
        check("R1 edge_warn in reset", W'(edge_warn), 1);
        rst = 0;
        wait_w(6);
        check("R1 in_rdy after release", W'(in_rdy), 1);
        check("R8 edge_warn empty", W'(edge_warn), 1);
    endtask

    task automatic t_fallthrough;
        // R2: wrong enable polarities store nothing
        @(negedge wclk); d = 18'h1234; wr_en_hi = 1; wr_en_lo_n = 1;
        @(negedge wclk); wr_en_hi = 0; wr_en_lo_n = 0;
        @(negedge wclk); wr_en_lo_n = 1;
        wait_r(10);
        check("R2 no store on bad enables", W'(out_rdy), '0);
        // R4: prefetch without read request, outputs disabled
        push(18'h2A5C3);
        wait_r(6);
        check("R4 out_rdy after first write", W'(out_rdy), 1);
        check("R10 q high-z both disabled", q, {W{1'bz}});
        oe_a_n = 0;
        rd_en_n = 0;
        wait_r(1);
        check("R10 q high-z one disabled", q, {W{1'bz}});
        wait_r(3);
        oe_b_n = 0; rd_en_n = 1;
        #1;
        check("R3 word held while oe_b_n high", q, 18'h2A5C3);
        check("R3 out_rdy held", W'(out_rdy), 1);
        void'(model.pop_front());
        rd_en_n = 0;
        wait_r(1);
        rd_en_n = 1;
        wait_r(1);
        check("R3 read consumes word", W'(out_rdy), '0);
        oe_a_n = 1; oe_b_n = 1;
    endtask

    task automatic t_fill;
        push(18'h10000);
        wait_r(8); wait_w(8);
        for (int n = 2; n <= 257; n++) begin
            push(W'(18'h10000 + n));
            if (n == 33)  check("R8 edge_warn at count 32", W'(edge_warn), 1);
            if (n == 34)  check("R8 edge_warn at count 33", W'(edge_warn), '0);
            if (n == 129) check("R7 half_full at count 128", W'(half_full), '0);
            if (n == 130) check("R7 half_full at count 129", W'(half_full), 1);
            if (n == 224) check("R8 edge_warn at count 223", W'(edge_warn), '0);
            if (n == 225) check("R8 edge_warn at count 224", W'(edge_warn), 1);
            if (n == 256) check("R6 in_rdy at count 255", W'(in_rdy), 1);
            if (n == 257) check("R6 in_rdy at count 256", W'(in_rdy), '0);
        end
        // R2: write attempted while in_rdy is low must be dropped
        @(negedge wclk); d = 18'h2BAD; wr_en_hi = 1; wr_en_lo_n = 0;
        wait_w(3);
        wr_en_hi = 0; wr_en_lo_n = 1;
        check("R2 in_rdy still low", W'(in_rdy), '0);
        drain("R5 fill order");
        wait_w(8);
        check("R6 in_rdy back after drain", W'(in_rdy), 1);
        check("R7 half_full clear after drain", W'(half_full), '0);
    endtask

    task automatic t_program;
        @(negedge wclk); d = 18'h3FF08; prg_n = 0; wr_en_hi = 1; wr_en_lo_n = 0;
        @(negedge wclk); prg_n = 1; wr_en_hi = 0; wr_en_lo_n = 1;
        wait_r(10);
        check("R9 offset load stores no word", W'(out_rdy), '0);
        push(18'h00100);
        wait_r(8); wait_w(8);
        for (int n = 1; n <= 9; n++) begin
            push(W'(18'h00100 + n));
            if (n == 8) check("R9 edge_warn at count 8 offset 8", W'(edge_warn), 1);
            if (n == 9) check("R9 edge_warn at count 9 offset 8", W'(edge_warn), '0);
        end
        drain("R9 data after offset load");
    endtask

    task automatic t_stream;
        int total = 400;
        int got = 0;
        fork
            begin
                int i = 0;
                while (i < total) begin
                    @(negedge wclk);
                    if (in_rdy && ($urandom % 3 != 0)) begin
                        d = W'($urandom); wr_en_hi = 1; wr_en_lo_n = 0;
                        model.push_back(d);
                        i++;
                    end else begin
                        wr_en_hi = 0; wr_en_lo_n = 1;
                    end
                end
                @(negedge wclk);
                wr_en_hi = 0; wr_en_lo_n = 1;
            end
            begin
                int guard = 0;
                oe_a_n = 0; oe_b_n = 0;
                while (got < total && guard < 20000) begin
                    @(negedge rclk);
                    guard++;
                    if (out_rdy && ($urandom % 2 == 0) && model.size() > 0) begin
                        check("R5 stream order", q, model.pop_front());
                        rd_en_n = 0;
                        got++;
                    end else begin
                        rd_en_n = 1;
                    end
                end
                @(negedge rclk);
                rd_en_n = 1; oe_a_n = 1; oe_b_n = 1;
            end
        join
        check("R5 stream word count", W'(got), W'(total));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_fallthrough();
        t_fill();
        t_program();
        t_stream();
        finish_run();
    end
endmodule